// File: doc/BRIEF.md
# Transmit Descriptor Chain Validator

This block sits next to a transmit DMA engine and checks each buffer descriptor of a packet as the engine walks the chain. Each descriptor comes in over a valid/ready handshake. It carries a buffer pointer, a buffer length, a next-descriptor pointer, start and end markers, an ownership flag and the packet length. A 3-bit channel number comes with it. The first descriptor of a packet opens the chain and supplies the packet length. The buffer lengths are summed up to the descriptor that carries the end marker.

The first rule a descriptor breaks ends the walk. A 4-bit error code and the channel are latched, a level interrupt rises, and the descriptor input stops accepting. Only a hardware reset leaves this state. A host read strobe clears the latched channel to 0 and leaves the code in place. An idle output shows that the block is out of reset and has no packet open.

Top module: `txd_chain_checker`

## Requirements
- R1: While `rst_n` is low: `err_code`=0, `err_chan`=0, `host_err_irq`=0, `dsc_ready`=1 and `idle`=0. `idle` becomes 1 at the first rising clock edge after reset is released.
- R2: An accepted descriptor that opens a packet without its start flag set latches code 1.
- R3: An accepted opening descriptor with its start flag set and its ownership flag clear latches code 2. The ownership and start flags of later descriptors in the chain are ignored.
- R4: An accepted descriptor with a buffer pointer of zero latches code 4.
- R5: An accepted descriptor with a buffer length of zero latches code 5.
- R6: An accepted descriptor with a next-descriptor pointer of zero and no end flag latches code 3.
- R7: When a descriptor breaks several rules, the code reported is the first that applies in this order: 1, 2, 4, 5, 3.
- R8: When the end descriptor is accepted with no other violation, code 6 is latched if the sum of all buffer lengths since the opening descriptor is less than the packet length. A sum equal to or greater than the packet length is legal, and so is a packet length of 0. The sum restarts at every opening descriptor.
- R9: The channel number is latched in the same cycle as the code. A `stat_rd` pulse clears `err_chan` to 0 on the next edge and leaves `err_code` unchanged. A capture in the same cycle takes precedence over the read.
- R10: All outputs are registered and update on the edge that accepts the descriptor. `host_err_irq` is 1 exactly when `err_code` is nonzero. Once an error is latched, `dsc_ready` stays 0, no further descriptor is accepted, and the code is held until reset.
- R11: `idle` is 0 from the acceptance of an opening descriptor without an end flag until the chain ends, either by an accepted end descriptor or by an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| dsc_valid | input | 1 | Descriptor present |
| dsc_ready | output | 1 | Block accepts a descriptor |
| dsc_buf_ptr | input | ADDR_W | Buffer pointer |
| dsc_buf_len | input | BLEN_W | Buffer length |
| dsc_next_ptr | input | ADDR_W | Next-descriptor pointer |
| dsc_sop | input | 1 | Start-of-packet flag |
| dsc_eop | input | 1 | End-of-packet flag |
| dsc_own | input | 1 | Ownership flag |
| dsc_pkt_len | input | PLEN_W | Packet length (used from the opening descriptor) |
| chan_id | input | 3 | Transmit channel of this descriptor |
| stat_rd | input | 1 | Host status read strobe |
| err_code | output | 4 | Latched error code, 0 when no error |
| err_chan | output | 3 | Latched error channel |
| host_err_irq | output | 1 | Sticky host-error interrupt level |
| idle | output | 1 | Out of reset and no packet open |

## Verification
The bench builds descriptors that break several rules at once, so a design with the wrong check order reports the wrong code. It sends a short packet right after a long legal one, so a sum that does not restart at the opening descriptor hides the code 6. It covers exact-length and zero-length packets, where an off-by-one compare would raise a false error. It also checks the ownership flag on a later descriptor, which must be ignored. After an error it keeps offering bad descriptors and issues host reads, so a design that clears the error, drops the code on a read, or re-asserts ready shows up as a changed code or a raised ready.

// File: rtl/txd_pkg.sv
`timescale 1ns/1ps
package txd_pkg;

  typedef enum logic [3:0] {
    ERR_NONE      = 4'd0,
    ERR_NO_SOP    = 4'd1,
    ERR_SOP_OWN   = 4'd2,
    ERR_NULL_NEXT = 4'd3,
    ERR_ZERO_PTR  = 4'd4,
    ERR_ZERO_LEN  = 4'd5,
    ERR_SHORT     = 4'd6
  } txd_err_e;

  // Priority order of the descriptor rules; the length-sum rule comes last.
  function automatic txd_err_e classify(input logic first, input logic sop,
                                        input logic own, input logic ptr_zero,
                                        input logic len_zero, input logic next_zero,
                                        input logic eop, input logic short_sum);
    txd_err_e c;
    c = ERR_NONE;
    if (first && !sop)               c = ERR_NO_SOP;
    else if (first && !own)          c = ERR_SOP_OWN;
    else if (ptr_zero)               c = ERR_ZERO_PTR;
    else if (len_zero)               c = ERR_ZERO_LEN;
    else if (next_zero && !eop)      c = ERR_NULL_NEXT;
    else if (eop && short_sum)       c = ERR_SHORT;
    return c;
  endfunction

endpackage

// File: rtl/txd_rule_check.sv
`timescale 1ns/1ps
module txd_rule_check
  import txd_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int BLEN_W = 16
) (
  input  logic              first,
  input  logic              sop,
  input  logic              eop,
  input  logic              own,
  input  logic [ADDR_W-1:0] buf_ptr,
  input  logic [BLEN_W-1:0] buf_len,
  input  logic [ADDR_W-1:0] next_ptr,
  input  logic              short_sum,
  output txd_err_e          code
);

  logic ptr_zero, len_zero, next_zero;

  assign ptr_zero  = (buf_ptr  == '0);
  assign len_zero  = (buf_len  == '0);
  assign next_zero = (next_ptr == '0);

  assign code = classify(first, sop, own, ptr_zero, len_zero, next_zero, eop, short_sum);

endmodule

// File: rtl/txd_len_accum.sv
`timescale 1ns/1ps
module txd_len_accum #(
  parameter int BLEN_W    = 16,
  parameter int PLEN_W    = 16,
  parameter int MAX_CHAIN = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              first,
  input  logic              eop,
  input  logic [BLEN_W-1:0] buf_len,
  input  logic [PLEN_W-1:0] pkt_len,
  output logic              short_sum
);

  localparam int SUM_W = BLEN_W + $clog2(MAX_CHAIN + 1);
  localparam int CMP_W = (SUM_W > PLEN_W) ? SUM_W : PLEN_W;

  logic [SUM_W-1:0]  acc_q, acc_base, acc_now;
  logic [PLEN_W-1:0] plen_q, plen_now;

  // Saturating add keeps an over-long chain from wrapping to a small sum.
  function automatic logic [SUM_W-1:0] sat_add(input logic [SUM_W-1:0] a,
                                               input logic [BLEN_W-1:0] b);
    logic [SUM_W:0] s;
    s = {1'b0, a} + (SUM_W+1)'(b);
    return s[SUM_W] ? {SUM_W{1'b1}} : s[SUM_W-1:0];
  endfunction

  assign acc_base  = first ? '0 : acc_q;
  assign acc_now   = sat_add(acc_base, buf_len);
  assign plen_now  = first ? pkt_len : plen_q;
  assign short_sum = eop && (CMP_W'(acc_now) < CMP_W'(plen_now));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      plen_q <= '0;
    end else if (accept) begin
      acc_q  <= acc_now;
      plen_q <= plen_now;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !first) |=> (acc_q >= $past(acc_q))); // R8

endmodule

// File: rtl/txd_err_latch.sv
`timescale 1ns/1ps
module txd_err_latch
  import txd_pkg::*;
#(
  parameter int CH_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            capture,
  input  txd_err_e        code,
  input  logic [CH_W-1:0] chan,
  input  logic            stat_rd,
  output logic [3:0]      err_code,
  output logic [CH_W-1:0] err_chan,
  output logic            err_flag
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_code <= '0;
      err_chan <= '0;
      err_flag <= 1'b0;
    end else begin
      if (stat_rd) err_chan <= '0;
      if (capture) begin
        err_code <= code;
        err_chan <= chan;
        err_flag <= 1'b1;
      end
    end
  end

  AST_CODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> (err_code == $past(err_code))); // R10
  AST_CHAN_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !capture) |=> (err_chan == '0)); // R9
  AST_CAPTURE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    capture |-> !err_flag); // R10

endmodule

// File: rtl/txd_chain_checker.sv
`timescale 1ns/1ps
module txd_chain_checker
  import txd_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int BLEN_W    = 16,
  parameter int PLEN_W    = 16,
  parameter int MAX_CHAIN = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dsc_valid,
  output logic              dsc_ready,
  input  logic [ADDR_W-1:0] dsc_buf_ptr,
  input  logic [BLEN_W-1:0] dsc_buf_len,
  input  logic [ADDR_W-1:0] dsc_next_ptr,
  input  logic              dsc_sop,
  input  logic              dsc_eop,
  input  logic              dsc_own,
  input  logic [PLEN_W-1:0] dsc_pkt_len,
  input  logic [2:0]        chan_id,
  input  logic              stat_rd,
  output logic [3:0]        err_code,
  output logic [2:0]        err_chan,
  output logic              host_err_irq,
  output logic              idle
);

  logic     in_pkt_q, started_q, err_flag;
  logic     accept, first, short_sum, capture;
  txd_err_e code;

  assign dsc_ready = !err_flag;
  assign accept    = dsc_valid && dsc_ready;
  assign first     = !in_pkt_q;
  assign capture   = accept && (code != ERR_NONE);

  txd_len_accum #(.BLEN_W(BLEN_W), .PLEN_W(PLEN_W), .MAX_CHAIN(MAX_CHAIN)) u_accum (
    .clk(clk), .rst_n(rst_n), .accept(accept), .first(first), .eop(dsc_eop),
    .buf_len(dsc_buf_len), .pkt_len(dsc_pkt_len), .short_sum(short_sum)
  );

  txd_rule_check #(.ADDR_W(ADDR_W), .BLEN_W(BLEN_W)) u_rules (
    .first(first), .sop(dsc_sop), .eop(dsc_eop), .own(dsc_own),
    .buf_ptr(dsc_buf_ptr), .buf_len(dsc_buf_len), .next_ptr(dsc_next_ptr),
    .short_sum(short_sum), .code(code)
  );

  txd_err_latch #(.CH_W(3)) u_err (
    .clk(clk), .rst_n(rst_n), .capture(capture), .code(code), .chan(chan_id),
    .stat_rd(stat_rd), .err_code(err_code), .err_chan(err_chan), .err_flag(err_flag)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_pkt_q  <= 1'b0;
      started_q <= 1'b0;
    end else begin
      started_q <= 1'b1;
      if (capture)     in_pkt_q <= 1'b0;
      else if (accept) in_pkt_q <= !dsc_eop;
    end
  end

  assign host_err_irq = err_flag;
  assign idle         = started_q && !in_pkt_q;

  AST_READY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    host_err_irq |-> !dsc_ready); // R10
  AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    host_err_irq == (err_code != 4'd0)); // R10
  AST_NO_SOP: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && first && !dsc_sop) |=> (err_code == 4'd1)); // R2
  AST_IDLE_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && dsc_eop && !capture) |=> idle); // R11

endmodule

// File: tb/sim_txd_chain_checker.sv
`timescale 1ns/1ps
module sim_txd_chain_checker;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dsc_valid = 1'b0;
  logic        dsc_ready;
  logic [31:0] dsc_buf_ptr = '0;
  logic [15:0] dsc_buf_len = '0;
  logic [31:0] dsc_next_ptr = '0;
  logic        dsc_sop = 1'b0, dsc_eop = 1'b0, dsc_own = 1'b0;
  logic [15:0] dsc_pkt_len = '0;
  logic [2:0]  chan_id = '0;
  logic        stat_rd = 1'b0;
  logic [3:0]  err_code;
  logic [2:0]  err_chan;
  logic        host_err_irq, idle;

  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  txd_chain_checker u0 (
    .clk(clk), .rst_n(rst_n), .dsc_valid(dsc_valid), .dsc_ready(dsc_ready),
    .dsc_buf_ptr(dsc_buf_ptr), .dsc_buf_len(dsc_buf_len), .dsc_next_ptr(dsc_next_ptr),
    .dsc_sop(dsc_sop), .dsc_eop(dsc_eop), .dsc_own(dsc_own), .dsc_pkt_len(dsc_pkt_len),
    .chan_id(chan_id), .stat_rd(stat_rd), .err_code(err_code), .err_chan(err_chan),
    .host_err_irq(host_err_irq), .idle(idle)
  );

  // Behavioural reference model
  int m_code = 0, m_chan = 0, m_sum = 0, m_plen = 0;
  bit m_open = 0, m_up = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_code = 0; m_chan = 0; m_sum = 0; m_plen = 0; m_open = 0; m_up = 0;
    end else begin
      int c, s, p;
      bit opening;
      m_up = 1;
      if (stat_rd) m_chan = 0;
      if (dsc_valid && m_code == 0) begin
        opening = !m_open;
        s = (opening ? 0 : m_sum) + int'(dsc_buf_len);
        p = opening ? int'(dsc_pkt_len) : m_plen;
        c = 0;
        if (opening && !dsc_sop)                 c = 1;
        else if (opening && !dsc_own)            c = 2;
        else if (dsc_buf_ptr == 0)               c = 4;
        else if (dsc_buf_len == 0)               c = 5;
        else if (dsc_next_ptr == 0 && !dsc_eop)  c = 3;
        else if (dsc_eop && s < p)               c = 6;
        if (c != 0) begin
          m_code = c; m_chan = int'(chan_id); m_open = 0;
        end else begin
          m_sum = s; m_plen = p; m_open = !dsc_eop;
        end
      end
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Compare against the model on every clock, away from the active edge
  always @(negedge clk) begin
    chk("R7", "model err_code", int'(err_code), m_code);
    chk("R9", "model err_chan", int'(err_chan), m_chan);
    chk("R10", "model irq", int'(host_err_irq), int'(m_code != 0));
    chk("R10", "model ready", int'(dsc_ready), int'(m_code == 0));
    chk("R11", "model idle", int'(idle), int'(m_up && !m_open));
  end

  task automatic do_reset();
    @(posedge clk); #1 rst_n = 1'b0;
    @(posedge clk); @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
  endtask

  // Offers a descriptor for one clock edge, then samples at the next falling edge
  task automatic send(input logic [31:0] ptr, input logic [15:0] len,
                      input logic [31:0] nxt, input bit sop, input bit eop,
                      input bit own, input logic [15:0] plen, input logic [2:0] ch);
    @(negedge clk);
    dsc_buf_ptr = ptr; dsc_buf_len = len; dsc_next_ptr = nxt;
    dsc_sop = sop; dsc_eop = eop; dsc_own = own; dsc_pkt_len = plen; chan_id = ch;
    dsc_valid = 1'b1;
    @(negedge clk);
    dsc_valid = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    // R1: reset values
    @(negedge clk);
    chk("R1", "code in reset", int'(err_code), 0);
    chk("R1", "irq in reset", int'(host_err_irq), 0);
    chk("R1", "ready in reset", int'(dsc_ready), 1);
    chk("R1", "idle in reset", int'(idle), 0);
    chk("R1", "chan in reset", int'(err_chan), 0);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "idle before first edge", int'(idle), 0);
    @(negedge clk);
    chk("R1", "idle one clock after release", int'(idle), 1);

    // R8: single-descriptor packet of exact length
    send(32'h100, 16'd64, 32'h0, 1, 1, 1, 16'd64, 3'd0);
    chk("R8", "exact length", int'(err_code), 0);
    // R8: packet length zero is legal
    send(32'h100, 16'd8, 32'h0, 1, 1, 1, 16'd0, 3'd0);
    chk("R8", "zero packet length", int'(err_code), 0);
    // R11 / R3: three-descriptor chain, later descriptors with own clear
    send(32'h200, 16'd100, 32'h300, 1, 0, 1, 16'd600, 3'd1);
    chk("R11", "idle low mid chain", int'(idle), 0);
    send(32'h300, 16'd200, 32'h400, 0, 0, 0, 16'd0, 3'd1);
    chk("R3", "own ignored mid chain", int'(err_code), 0);
    send(32'h400, 16'd300, 32'h0, 0, 1, 0, 16'd0, 3'd1);
    chk("R8", "sum equals length", int'(err_code), 0);
    chk("R11", "idle back after eop", int'(idle), 1);
    // R8: accumulator restarts: long legal packet then short packet
    send(32'h500, 16'd1000, 32'h0, 1, 1, 1, 16'd500, 3'd2);
    chk("R8", "long packet legal", int'(err_code), 0);
    send(32'h600, 16'd10, 32'h0, 1, 1, 1, 16'd20, 3'd4);
    chk("R8", "short after restart", int'(err_code), 6);
    chk("R9", "chan with short", int'(err_chan), 4);
    chk("R11", "idle after error", int'(idle), 1);

    // R10: sticky state, further descriptors refused
    chk("R10", "irq level", int'(host_err_irq), 1);
    chk("R10", "ready low", int'(dsc_ready), 0);
    send(32'h0, 16'd0, 32'h0, 0, 0, 0, 16'd0, 3'd7);
    chk("R10", "code held", int'(err_code), 6);
    chk("R10", "chan held", int'(err_chan), 4);
    // R9: host read clears channel only
    @(negedge clk); stat_rd = 1'b1;
    @(negedge clk); stat_rd = 1'b0;
    chk("R9", "chan cleared by read", int'(err_chan), 0);
    chk("R9", "code kept by read", int'(err_code), 6);
    repeat (3) @(negedge clk);
    chk("R10", "still in error", int'(host_err_irq), 1);

    // R8: multi-descriptor chain one short
    do_reset();
    send(32'h10, 16'd299, 32'h20, 1, 0, 1, 16'd600, 3'd5);
    send(32'h20, 16'd300, 32'h0, 0, 1, 1, 16'd0, 3'd5);
    chk("R8", "chain one short", int'(err_code), 6);
    chk("R9", "chain chan", int'(err_chan), 5);

    // R2
    do_reset();
    send(32'h10, 16'd4, 32'h0, 0, 1, 1, 16'd4, 3'd1);
    chk("R2", "no start flag", int'(err_code), 1);
    chk("R2", "chan", int'(err_chan), 1);
    // R3
    do_reset();
    send(32'h10, 16'd4, 32'h0, 1, 1, 0, 16'd4, 3'd2);
    chk("R3", "own clear at start", int'(err_code), 2);
    // R4
    do_reset();
    send(32'h0, 16'd4, 32'h0, 1, 1, 1, 16'd4, 3'd3);
    chk("R4", "zero pointer", int'(err_code), 4);
    // R5
    do_reset();
    send(32'h10, 16'd0, 32'h0, 1, 1, 1, 16'd0, 3'd6);
    chk("R5", "zero length", int'(err_code), 5);
    // R6: null next mid chain
    do_reset();
    send(32'h10, 16'd4, 32'h20, 1, 0, 1, 16'd8, 3'd7);
    send(32'h20, 16'd4, 32'h0, 0, 0, 1, 16'd0, 3'd7);
    chk("R6", "null next without end", int'(err_code), 3);
    chk("R6", "chan", int'(err_chan), 7);

    // R7: priority cases
    do_reset();
    send(32'h0, 16'd0, 32'h0, 0, 0, 0, 16'd9, 3'd1);
    chk("R7", "start flag first", int'(err_code), 1);
    do_reset();
    send(32'h0, 16'd0, 32'h0, 1, 0, 0, 16'd9, 3'd1);
    chk("R7", "own before pointer", int'(err_code), 2);
    do_reset();
    send(32'h0, 16'd0, 32'h0, 1, 0, 1, 16'd9, 3'd1);
    chk("R7", "pointer before length", int'(err_code), 4);
    do_reset();
    send(32'h10, 16'd0, 32'h0, 1, 0, 1, 16'd9, 3'd1);
    chk("R7", "length before null next", int'(err_code), 5);
    do_reset();
    send(32'h10, 16'd2, 32'h0, 1, 1, 1, 16'd9, 3'd1);
    chk("R7", "short checked last", int'(err_code), 6);

    // R9: capture wins over a read in the same cycle
    do_reset();
    @(negedge clk);
    dsc_buf_ptr = 32'h0; dsc_buf_len = 16'd4; dsc_next_ptr = 32'h0;
    dsc_sop = 1; dsc_eop = 1; dsc_own = 1; dsc_pkt_len = 16'd4; chan_id = 3'd6;
    dsc_valid = 1'b1; stat_rd = 1'b1;
    @(negedge clk);
    dsc_valid = 1'b0; stat_rd = 1'b0;
    chk("R9", "capture over read", int'(err_chan), 6);

    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule